// File: doc/BRIEF.md
# Register Renamer with Commit Recovery

This block maps the logical register indices of decoded instructions onto physical register tags. Each cycle it can take a group of up to two instructions. It returns, for each instruction, the physical tags of its two sources, a newly assigned physical destination tag, and the physical tag that the destination held before. That earlier tag travels with the instruction to retirement. When the instruction commits, the earlier tag is released.

Two tables are kept. The speculative table is written at rename. The architectural table is written only through the commit port. A free pool, held as one bit per physical register, supplies destination tags. When a flush is raised, the speculative table is loaded from the architectural table. The free pool is then rebuilt so that it holds every physical tag the architectural table does not name. Sources that depend on an earlier destination in the same group take that destination's new tag. With every write going to a fresh register, only true read-after-write links remain between instructions.

Top module: `reg_renamer`

## Requirements
- R1: After reset, logical register n maps to physical tag n in both tables. The free pool holds every tag from NUM_LOG up to NUM_PHYS-1. `out_valid` is 0.
- R2: Lane i of each flat per-lane bus occupies bits [i*width +: width]. The renamed tags of an accepted group appear on the outputs, with `out_valid` high, on the cycle after the accepting clock edge. Sources with no same-group producer read the speculative table.
- R3: Destination tags come from the free pool lowest-numbered first, with lane 0 served before lane 1. A lane whose `ren_has_dst` bit is 0 takes no tag.
- R4: A source that equals the destination of an earlier lane in the same group receives that lane's new tag instead of the table value.
- R5: `out_pold` returns the tag the destination held before. If an earlier lane in the same group writes the same logical register, the old tag is that lane's new tag, and the table ends at the later lane's tag.
- R6: `ren_ready` is low when the free pool holds fewer tags than the group's set `ren_has_dst` bits. A group offered while not ready is not accepted: nothing is allocated and `out_valid` stays low.
- R7: A commit writes `cmt_pnew` into the architectural table at `cmt_ldst` and returns `cmt_pold` to the free pool. The returned tag can be allocated from the next cycle.
- R8: While `flush` is high, `ren_ready` is low. After the flush edge, the speculative table equals the architectural table, including a commit made in the same cycle. The free pool is every tag the architectural table does not hold.
- R9: With `ren_valid` low, `out_valid` is low on the following cycle and the tables and pool are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | A rename group is offered |
| ren_has_dst | input | W | Per lane: the instruction writes a register |
| ren_src_a | input | W*LW | Per lane first logical source |
| ren_src_b | input | W*LW | Per lane second logical source |
| ren_dst | input | W*LW | Per lane logical destination |
| ren_ready | output | 1 | The group can be accepted this cycle |
| out_valid | output | 1 | Renamed group present on the outputs |
| out_psrc_a | output | W*PW | Per lane first physical source |
| out_psrc_b | output | W*PW | Per lane second physical source |
| out_pdst | output | W*PW | Per lane new physical destination |
| out_pold | output | W*PW | Per lane previous physical destination |
| cmt_valid | input | 1 | An instruction commits |
| cmt_ldst | input | LW | Logical destination of the committing instruction |
| cmt_pnew | input | PW | Its new physical tag |
| cmt_pold | input | PW | Its previous physical tag, to be freed |
| flush | input | 1 | Restore speculative state from the architectural table |

## Verification
`ren_ready` depends on the inputs of the same cycle. The bench therefore reads it shortly after driving a group, before the clock edge. Renamed tags are registered, so each group's results are read at the falling edge after the accepting rising edge. A commit or flush changes state at one rising edge, and its effect is checked in the tags of the group renamed at the following edge. The bench drives those cases back to back, with the expected tags worked out from the lowest-first allocation order.

// File: rtl/rn_pkg.sv
package rn_pkg;
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
  parameter int NUM_LOG  = 6,
  parameter int NUM_PHYS = 10,
  parameter int W        = 2,
  localparam int PW      = rn_pkg::idx_bits(NUM_PHYS),
  localparam int CW      = $clog2(NUM_PHYS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [W-1:0]           take,
  output logic [W-1:0][PW-1:0]   pick,
  output logic [CW-1:0]          free_cnt,
  output logic [NUM_PHYS-1:0]    free_mask,
  input  logic                   rel_en,
  input  logic [PW-1:0]          rel_tag,
  input  logic                   load_en,
  input  logic [NUM_PHYS-1:0]    load_mask
);
  logic [NUM_PHYS-1:0] free_q;
  logic [NUM_PHYS-1:0] avail;
  logic                found;

  always_comb begin
    avail = free_q;
    for (int i = 0; i < W; i++) begin
      pick[i] = '0;
      found   = 1'b0;
      for (int p = 0; p < NUM_PHYS; p++) begin
        if (!found && avail[p]) begin
          pick[i] = PW'(p);
          found   = 1'b1;
        end
      end
      if (take[i] && found) avail[pick[i]] = 1'b0;
    end
  end

  always_comb begin
    free_cnt = '0;
    for (int p = 0; p < NUM_PHYS; p++) free_cnt = free_cnt + CW'(free_q[p]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PHYS; p++) free_q[p] <= (p >= NUM_LOG);
    end else if (load_en) begin
      free_q <= load_mask;
    end else begin
      free_q <= avail;
      if (rel_en) free_q[rel_tag] <= 1'b1;
    end
  end

  assign free_mask = free_q;
endmodule

// File: rtl/rn_map.sv
module rn_map #(
  parameter int NUM_LOG  = 6,
  parameter int NUM_PHYS = 10,
  parameter int NRD      = 1,
  parameter int NWR      = 1,
  localparam int LW      = rn_pkg::idx_bits(NUM_LOG),
  localparam int PW      = rn_pkg::idx_bits(NUM_PHYS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NRD-1:0][LW-1:0]      rd_idx,
  output logic [NRD-1:0][PW-1:0]      rd_tag,
  input  logic [NWR-1:0]              wr_en,
  input  logic [NWR-1:0][LW-1:0]      wr_idx,
  input  logic [NWR-1:0][PW-1:0]      wr_tag,
  input  logic                        load_en,
  input  logic [NUM_LOG-1:0][PW-1:0]  load_tbl,
  output logic [NUM_LOG-1:0][PW-1:0]  tbl_nxt
);
  logic [NUM_LOG-1:0][PW-1:0] tbl_q;

  generate
    for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rd_tag[r] = tbl_q[rd_idx[r]];
    end
  endgenerate

  always_comb begin
    tbl_nxt = tbl_q;
    for (int w = 0; w < NWR; w++) begin
      if (wr_en[w]) tbl_nxt[wr_idx[w]] = wr_tag[w];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < NUM_LOG; l++) tbl_q[l] <= PW'(l);
    end else if (load_en) begin
      tbl_q <= load_tbl;
    end else begin
      tbl_q <= tbl_nxt;
    end
  end
endmodule

// File: rtl/rn_bypass.sv
module rn_bypass #(
  parameter int W  = 2,
  parameter int LW = 3,
  parameter int PW = 4
) (
  input  logic [W-1:0]          has_dst,
  input  logic [W-1:0][LW-1:0]  src_a,
  input  logic [W-1:0][LW-1:0]  src_b,
  input  logic [W-1:0][LW-1:0]  dst,
  input  logic [W-1:0][PW-1:0]  tbl_a,
  input  logic [W-1:0][PW-1:0]  tbl_b,
  input  logic [W-1:0][PW-1:0]  tbl_old,
  input  logic [W-1:0][PW-1:0]  new_tag,
  output logic [W-1:0][PW-1:0]  phys_a,
  output logic [W-1:0][PW-1:0]  phys_b,
  output logic [W-1:0][PW-1:0]  phys_old
);
  always_comb begin
    for (int i = 0; i < W; i++) begin
      phys_a[i]   = tbl_a[i];
      phys_b[i]   = tbl_b[i];
      phys_old[i] = tbl_old[i];
      for (int j = 0; j < i; j++) begin
        if (has_dst[j] && dst[j] == src_a[i]) phys_a[i]   = new_tag[j];
        if (has_dst[j] && dst[j] == src_b[i]) phys_b[i]   = new_tag[j];
        if (has_dst[j] && dst[j] == dst[i])   phys_old[i] = new_tag[j];
      end
    end
  end
endmodule

// File: rtl/reg_renamer.sv
module reg_renamer #(
  parameter int NUM_LOG  = 6,
  parameter int NUM_PHYS = 10,
  parameter int W        = 2,
  localparam int LW      = rn_pkg::idx_bits(NUM_LOG),
  localparam int PW      = rn_pkg::idx_bits(NUM_PHYS),
  localparam int CW      = $clog2(NUM_PHYS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ren_valid,
  input  logic [W-1:0]    ren_has_dst,
  input  logic [W*LW-1:0] ren_src_a,
  input  logic [W*LW-1:0] ren_src_b,
  input  logic [W*LW-1:0] ren_dst,
  output logic            ren_ready,
  output logic            out_valid,
  output logic [W*PW-1:0] out_psrc_a,
  output logic [W*PW-1:0] out_psrc_b,
  output logic [W*PW-1:0] out_pdst,
  output logic [W*PW-1:0] out_pold,
  input  logic            cmt_valid,
  input  logic [LW-1:0]   cmt_ldst,
  input  logic [PW-1:0]   cmt_pnew,
  input  logic [PW-1:0]   cmt_pold,
  input  logic            flush
);
  logic [W-1:0][LW-1:0]       src_a, src_b, dst;
  logic [3*W-1:0][LW-1:0]     rd_idx;
  logic [3*W-1:0][PW-1:0]     rd_tag;
  logic [W-1:0][PW-1:0]       tbl_a, tbl_b, tbl_old;
  logic [W-1:0][PW-1:0]       new_tag, phys_a, phys_b, phys_old;
  logic [NUM_LOG-1:0][PW-1:0] spec_nxt, arch_nxt;
  logic [NUM_PHYS-1:0]        pool_free, rebuilt;
  logic [CW-1:0]              free_cnt, need;
  logic [W-1:0]               take;
  logic                       accept;

  generate
    for (genvar i = 0; i < W; i++) begin : g_lane
      assign src_a[i]       = ren_src_a[i*LW +: LW];
      assign src_b[i]       = ren_src_b[i*LW +: LW];
      assign dst[i]         = ren_dst[i*LW +: LW];
      assign rd_idx[i]      = src_a[i];
      assign rd_idx[W+i]    = src_b[i];
      assign rd_idx[2*W+i]  = dst[i];
      assign tbl_a[i]       = rd_tag[i];
      assign tbl_b[i]       = rd_tag[W+i];
      assign tbl_old[i]     = rd_tag[2*W+i];
      assign take[i]        = accept && ren_has_dst[i];
    end
  endgenerate

  always_comb begin
    need = '0;
    for (int i = 0; i < W; i++) need = need + CW'(ren_has_dst[i]);
  end

  assign ren_ready = !flush && (free_cnt >= need);
  assign accept    = ren_valid && ren_ready;

  always_comb begin
    rebuilt = '1;
    for (int l = 0; l < NUM_LOG; l++) rebuilt[arch_nxt[l]] = 1'b0;
  end

  rn_free_pool #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .W(W)) u_pool (
    .clk(clk), .rst(rst), .take(take), .pick(new_tag), .free_cnt(free_cnt),
    .free_mask(pool_free), .rel_en(cmt_valid), .rel_tag(cmt_pold),
    .load_en(flush), .load_mask(rebuilt)
  );

  rn_map #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .NRD(3*W), .NWR(W)) u_spec (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_tag(rd_tag),
    .wr_en(take), .wr_idx(dst), .wr_tag(new_tag),
    .load_en(flush), .load_tbl(arch_nxt), .tbl_nxt(spec_nxt)
  );

  rn_map #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .NRD(1), .NWR(1)) u_arch (
    .clk(clk), .rst(rst), .rd_idx(cmt_ldst), .rd_tag(),
    .wr_en(cmt_valid), .wr_idx(cmt_ldst), .wr_tag(cmt_pnew),
    .load_en(1'b0), .load_tbl(spec_nxt), .tbl_nxt(arch_nxt)
  );

  rn_bypass #(.W(W), .LW(LW), .PW(PW)) u_byp (
    .has_dst(ren_has_dst), .src_a(src_a), .src_b(src_b), .dst(dst),
    .tbl_a(tbl_a), .tbl_b(tbl_b), .tbl_old(tbl_old), .new_tag(new_tag),
    .phys_a(phys_a), .phys_b(phys_b), .phys_old(phys_old)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= accept;
    end
    if (accept) begin
      out_psrc_a <= phys_a;
      out_psrc_b <= phys_b;
      out_pdst   <= new_tag;
      out_pold   <= phys_old;
    end
  end
endmodule

// File: rtl/reg_renamer_chk.sv
module reg_renamer_chk #(
  parameter int NUM_PHYS = 10,
  parameter int W        = 2,
  parameter int PW       = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                ren_valid,
  input logic                ren_ready,
  input logic [W-1:0]        ren_has_dst,
  input logic                out_valid,
  input logic [W*PW-1:0]     out_pdst,
  input logic                cmt_valid,
  input logic [PW-1:0]       cmt_pold,
  input logic                flush,
  input logic [NUM_PHYS-1:0] pool_free
);
  // R6
  accept_only_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(ren_valid && ren_ready));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ren_valid |=> !out_valid);
  // R8
  flush_block_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> !ren_ready);
  // R3
  taken_not_free_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(ren_has_dst[0])) |-> !pool_free[out_pdst[PW-1:0]]);
  // R7
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (cmt_valid && !flush) |=> pool_free[$past(cmt_pold)]);
  generate
    if (W >= 2) begin : g_pair
      // R3
      distinct_tags_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(ren_has_dst[1:0]) == 2'b11)
          |-> out_pdst[PW-1:0] != out_pdst[2*PW-1:PW]);
    end
  endgenerate
endmodule

bind reg_renamer reg_renamer_chk #(.NUM_PHYS(NUM_PHYS), .W(W), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_ready(ren_ready),
  .ren_has_dst(ren_has_dst), .out_valid(out_valid), .out_pdst(out_pdst),
  .cmt_valid(cmt_valid), .cmt_pold(cmt_pold), .flush(flush),
  .pool_free(pool_free)
);

// File: tb/sim_reg_renamer.sv
module sim_reg_renamer;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 6, NP = 10, W = 2, LW = 3, PW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic ren_valid = 1'b0, cmt_valid = 1'b0, flush = 1'b0;
  logic [W-1:0] ren_has_dst = '0;
  logic [W*LW-1:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
  logic ren_ready, out_valid;
  logic [W*PW-1:0] out_psrc_a, out_psrc_b, out_pdst, out_pold;
  logic [LW-1:0] cmt_ldst = '0;
  logic [PW-1:0] cmt_pnew = '0, cmt_pold = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_renamer #(.NUM_LOG(NL), .NUM_PHYS(NP), .W(W)) u0 (
    .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_has_dst(ren_has_dst),
    .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
    .ren_ready(ren_ready), .out_valid(out_valid), .out_psrc_a(out_psrc_a),
    .out_psrc_b(out_psrc_b), .out_pdst(out_pdst), .out_pold(out_pold),
    .cmt_valid(cmt_valid), .cmt_ldst(cmt_ldst), .cmt_pnew(cmt_pnew),
    .cmt_pold(cmt_pold), .flush(flush)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic offer(input logic [1:0] has,
                       input int a0, input int b0, input int d0,
                       input int a1, input int b1, input int d1);
    ren_valid   = 1'b1;
    ren_has_dst = has;
    ren_src_a   = {LW'(a1), LW'(a0)};
    ren_src_b   = {LW'(b1), LW'(b0)};
    ren_dst     = {LW'(d1), LW'(d0)};
    #1;
  endtask

  task automatic idle();
    ren_valid = 1'b0;
    ren_has_dst = '0;
  endtask

  task automatic lane(input string req, input int i, input int pa, input int pb,
                      input int pd, input int po);
    check({req, " psrc_a"}, out_psrc_a[i*PW +: PW], pa);
    check({req, " psrc_b"}, out_psrc_b[i*PW +: PW], pb);
    if (pd >= 0) check({req, " pdst"}, out_pdst[i*PW +: PW], pd);
    if (po >= 0) check({req, " pold"}, out_pold[i*PW +: PW], po);
  endtask

  task automatic t_reset();
    check("R1 out_valid after reset", out_valid, 0);
    offer(2'b00, 3, 5, 0, 0, 1, 0);
    check("R1 ready with empty need", ren_ready, 1);
    step();
    check("R2 out_valid", out_valid, 1);
    lane("R1 identity lane0", 0, 3, 5, -1, -1);
    lane("R1 identity lane1", 1, 0, 1, -1, -1);
    idle();
    step();
    check("R9 idle out_valid", out_valid, 0);
  endtask

  task automatic t_bypass();
    offer(2'b11, 2, 3, 1, 1, 1, 2);
    check("R6 ready with 4 free", ren_ready, 1);
    step();
    lane("R3 alloc lane0", 0, 2, 3, 6, 1);
    lane("R4 bypass lane1", 1, 6, 6, 7, 2);
    idle();
  endtask

  task automatic t_waw();
    offer(2'b11, 1, 4, 4, 4, 2, 4);
    step();
    lane("R2 table read lane0", 0, 6, 4, 8, 4);
    lane("R5 same-group old lane1", 1, 8, 7, 9, 8);
    idle();
  endtask

  task automatic t_stall();
    offer(2'b01, 0, 0, 0, 0, 0, 0);
    check("R6 ready low when pool empty", ren_ready, 0);
    step();
    check("R6 no output when stalled", out_valid, 0);
    offer(2'b00, 4, 1, 0, 0, 0, 0);
    check("R3 no-dst group ready", ren_ready, 1);
    step();
    lane("R5 final WAW map", 0, 9, 6, -1, -1);
    idle();
  endtask

  task automatic t_commit();
    cmt_valid = 1'b1; cmt_ldst = 3'd1; cmt_pnew = 4'd6; cmt_pold = 4'd1;
    step();
    cmt_valid = 1'b0;
    offer(2'b11, 0, 0, 0, 0, 0, 1);
    check("R6 one free but two needed", ren_ready, 0);
    offer(2'b01, 4, 2, 0, 0, 0, 0);
    check("R7 released tag makes ready", ren_ready, 1);
    step();
    lane("R7 released tag reused", 0, 9, 7, 1, 0);
    idle();
  endtask

  task automatic t_flush();
    flush = 1'b1;
    offer(2'b00, 0, 0, 0, 0, 0, 0);
    check("R8 ready low in flush", ren_ready, 0);
    step();
    flush = 1'b0;
    check("R8 no output in flush", out_valid, 0);
    offer(2'b00, 1, 2, 0, 4, 0, 0);
    step();
    lane("R8 restored lane0", 0, 6, 2, -1, -1);
    lane("R8 restored lane1", 1, 4, 0, -1, -1);
    offer(2'b11, 3, 3, 3, 3, 5, 5);
    step();
    lane("R8 rebuilt pool lane0", 0, 3, 3, 1, 3);
    lane("R8 rebuilt pool lane1", 1, 1, 5, 7, 5);
    idle();
  endtask

  task automatic t_commit_flush();
    cmt_valid = 1'b1; cmt_ldst = 3'd3; cmt_pnew = 4'd1; cmt_pold = 4'd3;
    flush = 1'b1;
    step();
    cmt_valid = 1'b0; flush = 1'b0;
    offer(2'b11, 3, 1, 0, 0, 4, 2);
    step();
    lane("R8 commit with flush lane0", 0, 1, 6, 3, 0);
    lane("R8 commit with flush lane1", 1, 3, 4, 7, 2);
    idle();
    step();
    check("R9 idle again", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bypass();
    t_waw();
    t_stall();
    t_commit();
    t_flush();
    t_commit_flush();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule